// File: doc/BRIEF.md
# Change-of-Flow Trace Capture Buffer

This block watches two bus masters and keeps a circular record of their program change-of-flow events for on-chip debug. One master is a main CPU with a 23-bit address bus; the other is a coprocessor with a 16-bit address bus. For each retired instruction a master presents a decoded class code, a taken flag, the instruction's own (source) address and its target (destination) address. The main CPU also reports interrupt vector fetches on a separate strobe, tagged with the vector kind.

A filter per master decides whether the event is kept and which of the two addresses is recorded. Kept events pass through a small ordering queue, which accepts up to three entries in one cycle, and are written one per cycle into a 64-entry store. Each stored entry pairs the address with an information byte that tells whether a source or a destination address was captured, which master produced it, and which class it came from. Recording runs only while `arm` is high. After `arm` drops, the write pointer freezes and the contents can be read by index through a synchronous read port. Raising `arm` again restarts the record from slot 0.

Top module: `cof_trace_buffer`

## Requirements
- R1: A main-CPU or coprocessor event of class 1 (conditional branch) with the taken flag high stores the source address with info bit 0 set. With the taken flag low, it stores nothing.
- R2: A main-CPU event of class 2 (return from interrupt, subroutine or call) stores the destination address with info bit 0 clear.
- R3: A main-CPU event of class 4 (indexed jump or call) stores the destination address. Main-CPU classes 0, 3 (direct or unconditional flow: relative and long branches, branch-to-subroutine, background entry, non-indexed jumps and calls), 5 and 6 store nothing.
- R4: A main-CPU vector strobe of kind 0 (ordinary interrupt) stores the vector address with class code 7 and info bit 0 clear. Kinds 1 (software interrupt) and 2 (debug entry) store nothing.
- R5: A coprocessor event of class 5 (indexed jump-and-link) or class 6 (first address of a new thread) stores the destination address. The 16-bit coprocessor address is zero-extended to 23 bits and info bit 1 is set. Coprocessor classes 2, 3 and 4 store nothing.
- R6: When several kept events arrive in one cycle, they go into consecutive slots in this order: main-CPU instruction event, then main-CPU vector, then coprocessor event. This holds even when a destination event and an interrupt coincide.
- R7: The information byte holds the class code in bits 7:4, zeros in bits 3:2, the master in bit 1 (1 = coprocessor) and the source flag in bit 0. The write pointer advances by exactly one per stored entry. After reset the pointer is 0, `wrapped` is 0 and every entry reads as zero.
- R8: The write pointer wraps from 63 to 0. `wrapped` is set on the first wrap and stays set while recording continues.
- R9: While `arm` is low, no event is recorded, the write pointer holds and the stored contents are preserved. A rising `arm` clears the pointer and `wrapped`.
- R10: `rd_addr` and `rd_info` show the entry selected by `rd_idx` one clock after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Recording enable; a rising edge restarts the record |
| cpu_valid | input | 1 | Main-CPU instruction retire strobe |
| cpu_cls | input | 4 | Main-CPU instruction class code |
| cpu_taken | input | 1 | Main-CPU branch taken flag |
| cpu_src | input | 23 | Main-CPU instruction address |
| cpu_dst | input | 23 | Main-CPU target address |
| cpu_vec_valid | input | 1 | Main-CPU interrupt vector fetch strobe |
| cpu_vec_kind | input | 2 | Vector kind: 0 ordinary, 1 software, 2 debug |
| cpu_vec_addr | input | 23 | Vector address |
| cop_valid | input | 1 | Coprocessor instruction retire strobe |
| cop_cls | input | 4 | Coprocessor instruction class code |
| cop_taken | input | 1 | Coprocessor branch taken flag |
| cop_src | input | 16 | Coprocessor instruction address |
| cop_dst | input | 16 | Coprocessor target address |
| rd_idx | input | 6 | Read index into the store |
| rd_addr | output | 23 | Address field of the entry read |
| rd_info | output | 8 | Information byte of the entry read |
| wr_ptr | output | 6 | Next slot to be written |
| wrapped | output | 1 | Sticky flag: the pointer has wrapped |

## Verification
The hardest case to reach from the ports is three kept events in one cycle: a main-CPU return, an ordinary interrupt vector and a coprocessor jump-and-link. These force the ordering queue to hold two entries while the first is written. The vector table includes that triple and a mixed triple in which the middle event is filtered out, and the bench reads back the consecutive slots to confirm the order. The wrap boundary is reached by streaming one taken branch per cycle. The bench stops at exactly 63 entries to confirm that `wrapped` is still clear, then continues past the wrap.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;

   localparam int ADDR_W = 23;

   typedef struct packed {
      logic [7:0]        info;
      logic [ADDR_W-1:0] addr;
   } trace_entry_t;

   localparam logic [3:0] CLS_NONE       = 4'd0;
   localparam logic [3:0] CLS_COND       = 4'd1;
   localparam logic [3:0] CLS_RETURN     = 4'd2;
   localparam logic [3:0] CLS_DIRECT     = 4'd3;
   localparam logic [3:0] CLS_INDEXED    = 4'd4;
   localparam logic [3:0] CLS_COP_JAL    = 4'd5;
   localparam logic [3:0] CLS_COP_THREAD = 4'd6;
   localparam logic [3:0] CLS_VECTOR     = 4'd7;

   localparam logic [1:0] VEC_ORDINARY = 2'd0;
   localparam logic [1:0] VEC_SOFT     = 2'd1;
   localparam logic [1:0] VEC_DEBUG    = 2'd2;

   function automatic logic [7:0] make_info(logic [3:0] cls, logic from_cop, logic is_src);
      return {cls, 2'b00, from_cop, is_src};
   endfunction

endpackage

// File: rtl/cof_event_filter.sv
module cof_event_filter
   import cof_trace_pkg::*;
#(
   parameter int AW     = 23,
   parameter bit IS_COP = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           valid,
   input  logic [3:0]     cls,
   input  logic           taken,
   input  logic [AW-1:0]  src,
   input  logic [AW-1:0]  dst,
   input  logic           vec_valid,
   input  logic [1:0]     vec_kind,
   input  logic [AW-1:0]  vec_addr,
   output logic           cof_keep,
   output trace_entry_t   cof_ent,
   output logic           vec_keep,
   output trace_entry_t   vec_ent
);

   generate
      if (AW > ADDR_W) begin : g_bad_width
         $error("cof_event_filter: AW exceeds the stored address width");
      end
   endgenerate

   logic take_src;
   logic take_dst;

   generate
      if (IS_COP) begin : g_cop
         always_comb begin
            take_src = valid && (cls == CLS_COND) && taken;
            take_dst = valid && ((cls == CLS_COP_JAL) || (cls == CLS_COP_THREAD));
         end
      end else begin : g_cpu
         always_comb begin
            take_src = valid && (cls == CLS_COND) && taken;
            take_dst = valid && ((cls == CLS_RETURN) || (cls == CLS_INDEXED));
         end
      end
   endgenerate

   always_comb begin
      cof_keep     = take_src || take_dst;
      cof_ent.addr = take_src ? ADDR_W'(src) : ADDR_W'(dst);
      cof_ent.info = make_info(cls, IS_COP, take_src);
      vec_keep     = !IS_COP && vec_valid && (vec_kind == VEC_ORDINARY);
      vec_ent.addr = ADDR_W'(vec_addr);
      vec_ent.info = make_info(CLS_VECTOR, IS_COP, 1'b0);
   end

   assert_src_needs_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cof_keep && cof_ent.info[0]) |-> (taken && cls == CLS_COND));

   assert_narrow_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (IS_COP && cof_keep) |-> (cof_ent.addr >> AW) == '0);

endmodule

// File: rtl/cof_pend_queue.sv
module cof_pend_queue
   import cof_trace_pkg::*;
#(
   parameter int PD    = 4,
   parameter int LANES = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     pop_en,
   input  logic [LANES-1:0]         in_vld,
   input  trace_entry_t [LANES-1:0] in_ent,
   output logic                     out_vld,
   output trace_entry_t             out_ent
);

   localparam int IW = $clog2(PD);
   localparam int CW = $clog2(PD + 1);
   localparam int SW = $clog2(PD + LANES + 1) + 1;

   generate
      if (PD < 2 || (1 << IW) != PD) begin : g_bad_depth
         $error("cof_pend_queue: PD must be a power of two, at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("cof_pend_queue: LANES must be at least 1");
      end
   endgenerate

   trace_entry_t q [PD];
   logic [IW-1:0] head;
   logic [CW-1:0] cnt;
   logic [IW-1:0] wr_idx [LANES];
   logic [SW-1:0] push_n;
   logic [SW-1:0] cnt_nx;
   logic          pop;

   always_comb begin
      push_n = '0;
      for (int i = 0; i < LANES; i++) begin
         wr_idx[i] = head + IW'(cnt) + IW'(push_n);
         push_n    = push_n + SW'(in_vld[i]);
      end
      pop    = pop_en && (cnt != '0);
      cnt_nx = SW'(cnt) + push_n - SW'(pop);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head <= '0;
         cnt  <= '0;
      end else begin
         head <= head + IW'(pop);
         cnt  <= CW'(cnt_nx);
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         if (in_vld[i] && !flush) q[wr_idx[i]] <= in_ent[i];
      end
   end

   always_comb begin
      out_vld = (cnt != '0);
      out_ent = q[head];
   end

   assert_queue_room_R6: assert property (@(posedge clk) disable iff (!rst_n || flush)
      cnt_nx <= SW'(PD));

endmodule

// File: rtl/cof_trace_store.sv
module cof_trace_store
   import cof_trace_pkg::*;
#(
   parameter int DEPTH = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     arm,
   input  logic                     wr_en,
   input  trace_entry_t             wr_ent,
   input  logic [$clog2(DEPTH)-1:0] rd_idx,
   output trace_entry_t             rd_ent,
   output logic [$clog2(DEPTH)-1:0] wr_ptr,
   output logic                     wrapped
);

   localparam int PW = $clog2(DEPTH);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   generate
      if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
         $error("cof_trace_store: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   trace_entry_t mem [DEPTH];
   logic arm_q;
   logic restart;
   logic do_wr;

   always_comb begin
      restart = arm && !arm_q;
      do_wr   = arm && wr_en && !restart;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q   <= 1'b0;
         wr_ptr  <= '0;
         wrapped <= 1'b0;
      end else begin
         arm_q <= arm;
         if (restart) begin
            wr_ptr  <= '0;
            wrapped <= 1'b0;
         end else if (do_wr) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (wr_ptr == LAST) wrapped <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         rd_ent <= '0;
      end else begin
         if (do_wr) mem[wr_ptr] <= wr_ent;
         rd_ent <= mem[rd_idx];
      end
   end

   assert_frozen_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(arm) |-> $stable(wr_ptr));

   assert_wrap_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wrapped) |-> (wr_ptr == '0));

   assert_wrap_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wrapped && arm && arm_q) |=> wrapped);

endmodule

// File: rtl/cof_trace_buffer.sv
module cof_trace_buffer
   import cof_trace_pkg::*;
#(
   parameter int CPU_AW     = 23,
   parameter int COP_AW     = 16,
   parameter int DEPTH      = 64,
   parameter int PEND_DEPTH = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     arm,
   input  logic                     cpu_valid,
   input  logic [3:0]               cpu_cls,
   input  logic                     cpu_taken,
   input  logic [CPU_AW-1:0]        cpu_src,
   input  logic [CPU_AW-1:0]        cpu_dst,
   input  logic                     cpu_vec_valid,
   input  logic [1:0]               cpu_vec_kind,
   input  logic [CPU_AW-1:0]        cpu_vec_addr,
   input  logic                     cop_valid,
   input  logic [3:0]               cop_cls,
   input  logic                     cop_taken,
   input  logic [COP_AW-1:0]        cop_src,
   input  logic [COP_AW-1:0]        cop_dst,
   input  logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic [CPU_AW-1:0]        rd_addr,
   output logic [7:0]               rd_info,
   output logic [$clog2(DEPTH)-1:0] wr_ptr,
   output logic                     wrapped
);

   localparam int LANES = 3;

   generate
      if (CPU_AW != ADDR_W) begin : g_bad_cpu_aw
         $error("cof_trace_buffer: CPU_AW must equal the stored address width");
      end
      if (COP_AW > CPU_AW) begin : g_bad_cop_aw
         $error("cof_trace_buffer: COP_AW must not exceed CPU_AW");
      end
   endgenerate

   logic         cpu_keep, cpu_vkeep, cop_keep, cop_vkeep_unused;
   trace_entry_t cpu_ent, cpu_vent, cop_ent, cop_vent_unused;

   cof_event_filter #(.AW(CPU_AW), .IS_COP(1'b0)) u_cpu_filter (
      .clk(clk), .rst_n(rst_n),
      .valid(cpu_valid), .cls(cpu_cls), .taken(cpu_taken),
      .src(cpu_src), .dst(cpu_dst),
      .vec_valid(cpu_vec_valid), .vec_kind(cpu_vec_kind), .vec_addr(cpu_vec_addr),
      .cof_keep(cpu_keep), .cof_ent(cpu_ent),
      .vec_keep(cpu_vkeep), .vec_ent(cpu_vent)
   );

   cof_event_filter #(.AW(COP_AW), .IS_COP(1'b1)) u_cop_filter (
      .clk(clk), .rst_n(rst_n),
      .valid(cop_valid), .cls(cop_cls), .taken(cop_taken),
      .src(cop_src), .dst(cop_dst),
      .vec_valid(1'b0), .vec_kind(VEC_ORDINARY), .vec_addr('0),
      .cof_keep(cop_keep), .cof_ent(cop_ent),
      .vec_keep(cop_vkeep_unused), .vec_ent(cop_vent_unused)
   );

   logic [LANES-1:0]         lane_vld;
   trace_entry_t [LANES-1:0] lane_ent;
   logic                     q_vld;
   trace_entry_t             q_ent;
   trace_entry_t             rd_ent;

   always_comb begin
      lane_vld    = {cop_keep, cpu_vkeep, cpu_keep} & {LANES{arm}};
      lane_ent[0] = cpu_ent;
      lane_ent[1] = cpu_vent;
      lane_ent[2] = cop_ent;
   end

   cof_pend_queue #(.PD(PEND_DEPTH), .LANES(LANES)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .flush(!arm), .pop_en(arm),
      .in_vld(lane_vld), .in_ent(lane_ent),
      .out_vld(q_vld), .out_ent(q_ent)
   );

   cof_trace_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .arm(arm),
      .wr_en(q_vld), .wr_ent(q_ent),
      .rd_idx(rd_idx), .rd_ent(rd_ent),
      .wr_ptr(wr_ptr), .wrapped(wrapped)
   );

   always_comb begin
      rd_addr = rd_ent.addr;
      rd_info = rd_ent.info;
   end

endmodule

// File: tb/cof_trace_buffer_tb.sv
module cof_trace_buffer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 15;

   // fields: cpu_cls[14:11] cpu_taken[10] vec_v[9] vec_kind[8:7] cop_cls[6:3] cop_taken[2] exp_n[1:0]
   localparam logic [14:0] VECS [NVEC] = '{
      {4'd1, 1'b1, 1'b0, 2'd0, 4'd0, 1'b0, 2'd1},   // R1 taken branch
      {4'd1, 1'b0, 1'b0, 2'd0, 4'd0, 1'b0, 2'd0},   // R1 not taken
      {4'd2, 1'b0, 1'b0, 2'd0, 4'd0, 1'b0, 2'd1},   // R2 return
      {4'd4, 1'b0, 1'b0, 2'd0, 4'd0, 1'b0, 2'd1},   // R3 indexed
      {4'd3, 1'b1, 1'b0, 2'd0, 4'd0, 1'b0, 2'd0},   // R3 direct
      {4'd0, 1'b0, 1'b1, 2'd0, 4'd0, 1'b0, 2'd1},   // R4 ordinary vector
      {4'd0, 1'b0, 1'b1, 2'd1, 4'd0, 1'b0, 2'd0},   // R4 software vector
      {4'd0, 1'b0, 1'b1, 2'd2, 4'd0, 1'b0, 2'd0},   // R4 debug vector
      {4'd0, 1'b0, 1'b0, 2'd0, 4'd5, 1'b0, 2'd1},   // R5 jal
      {4'd0, 1'b0, 1'b0, 2'd0, 4'd6, 1'b0, 2'd1},   // R5 thread start
      {4'd0, 1'b0, 1'b0, 2'd0, 4'd2, 1'b0, 2'd0},   // R5 cop return ignored
      {4'd0, 1'b0, 1'b0, 2'd0, 4'd1, 1'b1, 2'd1},   // R5 cop taken branch
      {4'd2, 1'b0, 1'b1, 2'd0, 4'd5, 1'b0, 2'd3},   // R6 triple
      {4'd1, 1'b1, 1'b1, 2'd1, 4'd6, 1'b0, 2'd2},   // R6 mixed
      {4'd5, 1'b0, 1'b0, 2'd0, 4'd0, 1'b0, 2'd0}    // R3 cop class on cpu
   };

   logic        clk = 1'b0;
   logic        rst_n, arm;
   logic        cpu_valid, cpu_taken, cpu_vec_valid, cop_valid, cop_taken;
   logic [3:0]  cpu_cls, cop_cls;
   logic [1:0]  cpu_vec_kind;
   logic [22:0] cpu_src, cpu_dst, cpu_vec_addr;
   logic [15:0] cop_src, cop_dst;
   logic [5:0]  rd_idx, wr_ptr;
   logic [22:0] rd_addr;
   logic [7:0]  rd_info;
   logic        wrapped;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cof_trace_buffer u_dut (
      .clk(clk), .rst_n(rst_n), .arm(arm),
      .cpu_valid(cpu_valid), .cpu_cls(cpu_cls), .cpu_taken(cpu_taken),
      .cpu_src(cpu_src), .cpu_dst(cpu_dst),
      .cpu_vec_valid(cpu_vec_valid), .cpu_vec_kind(cpu_vec_kind), .cpu_vec_addr(cpu_vec_addr),
      .cop_valid(cop_valid), .cop_cls(cop_cls), .cop_taken(cop_taken),
      .cop_src(cop_src), .cop_dst(cop_dst),
      .rd_idx(rd_idx), .rd_addr(rd_addr), .rd_info(rd_info),
      .wr_ptr(wr_ptr), .wrapped(wrapped)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] info_of(logic [3:0] cls, logic cop, logic src);
      return {cls, 2'b00, cop, src};
   endfunction

   task automatic idle_inputs();
      cpu_valid = 0; cpu_vec_valid = 0; cop_valid = 0;
      cpu_cls = 0; cpu_taken = 0; cop_cls = 0; cop_taken = 0; cpu_vec_kind = 0;
   endtask

   task automatic read_entry(input logic [5:0] idx, output logic [22:0] a, output logic [7:0] inf);
      @(negedge clk) rd_idx = idx;
      @(negedge clk);
      a = rd_addr; inf = rd_info;
   endtask

   logic [22:0] exp_a [3];
   logic [7:0]  exp_i [3];
   int          exp_cnt;

   task automatic push_exp(logic [22:0] a, logic [7:0] inf);
      exp_a[exp_cnt] = a; exp_i[exp_cnt] = inf; exp_cnt++;
   endtask

   task automatic apply_vec(int v);
      logic [14:0] e;
      logic [5:0]  base;
      logic [22:0] ra;
      logic [7:0]  ri;
      e = VECS[v];
      base = wr_ptr;
      exp_cnt = 0;
      @(negedge clk);
      cpu_cls = e[14:11]; cpu_taken = e[10]; cpu_valid = 1;
      cpu_src = 23'h400000 | 23'(v*16 + 1);
      cpu_dst = 23'h200000 | 23'(v*16 + 2);
      cpu_vec_valid = e[9]; cpu_vec_kind = e[8:7];
      cpu_vec_addr = 23'h7FFF00 | 23'(v);
      cop_cls = e[6:3]; cop_taken = e[2]; cop_valid = 1;
      cop_src = 16'hA000 | 16'(v);
      cop_dst = 16'h5000 | 16'(v);
      // expected entries from the requirements, in R6 order
      if (cpu_cls == 4'd1 && cpu_taken) push_exp(cpu_src, info_of(4'd1, 0, 1));
      else if (cpu_cls == 4'd2 || cpu_cls == 4'd4) push_exp(cpu_dst, info_of(cpu_cls, 0, 0));
      if (cpu_vec_valid && cpu_vec_kind == 2'd0) push_exp(cpu_vec_addr, info_of(4'd7, 0, 0));
      if (cop_cls == 4'd1 && cop_taken) push_exp({7'd0, cop_src}, info_of(4'd1, 1, 1));
      else if (cop_cls == 4'd5 || cop_cls == 4'd6) push_exp({7'd0, cop_dst}, info_of(cop_cls, 1, 0));
      @(negedge clk) idle_inputs();
      repeat (5) @(negedge clk);
      chk($sformatf("R7 vector %0d pointer step", v), 32'(wr_ptr - base), 32'(e[1:0]));
      chk($sformatf("R7 vector %0d model count", v), 32'(exp_cnt), 32'(e[1:0]));
      for (int k = 0; k < exp_cnt; k++) begin
         read_entry(base + 6'(k), ra, ri);
         chk($sformatf("R10/R6 vector %0d slot %0d addr", v, k), 32'(ra), 32'(exp_a[k]));
         chk($sformatf("R7 vector %0d slot %0d info", v, k), 32'(ri), 32'(exp_i[k]));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [22:0] ra;
      logic [7:0]  ri;
      logic [5:0]  frozen;
      rst_n = 0; arm = 0; rd_idx = 0;
      cpu_src = 0; cpu_dst = 0; cpu_vec_addr = 0; cop_src = 0; cop_dst = 0;
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R7 reset state
      chk("R7 reset pointer", 32'(wr_ptr), 0);
      chk("R7 reset wrapped", 32'(wrapped), 0);
      read_entry(6'd5, ra, ri);
      chk("R7 reset entry", {1'b0, ri, ra}, 0);

      @(negedge clk) arm = 1;
      @(negedge clk);
      for (int v = 0; v < NVEC; v++) apply_vec(v);

      // R9 disarm: no recording, pointer frozen, contents preserved
      @(negedge clk) arm = 0;
      @(negedge clk);
      frozen = wr_ptr;
      cpu_valid = 1; cpu_cls = 4'd2; cpu_dst = 23'h123456;
      cop_valid = 1; cop_cls = 4'd5; cop_dst = 16'hBEEF;
      @(negedge clk) idle_inputs();
      repeat (4) @(negedge clk);
      chk("R9 pointer frozen", 32'(wr_ptr), 32'(frozen));
      read_entry(frozen, ra, ri);
      chk("R9 slot untouched", 32'(ra), 0);
      read_entry(6'd0, ra, ri);
      chk("R9 R10 contents kept", 32'(ra), 32'h400001);

      // R9 rearm clears pointer
      @(negedge clk) arm = 1;
      @(negedge clk);
      chk("R9 rearm pointer", 32'(wr_ptr), 0);

      // R8 wrap: 63 entries, then 3 more
      for (int i = 0; i < 63; i++) begin
         cpu_valid = 1; cpu_cls = 4'd1; cpu_taken = 1; cpu_src = 23'(i);
         @(negedge clk);
      end
      idle_inputs();
      repeat (3) @(negedge clk);
      chk("R8 pointer at 63", 32'(wr_ptr), 63);
      chk("R8 not yet wrapped", 32'(wrapped), 0);
      for (int i = 63; i < 66; i++) begin
         cpu_valid = 1; cpu_cls = 4'd1; cpu_taken = 1; cpu_src = 23'(i);
         @(negedge clk);
      end
      idle_inputs();
      repeat (3) @(negedge clk);
      chk("R8 pointer after wrap", 32'(wr_ptr), 2);
      chk("R8 wrapped set", 32'(wrapped), 1);
      read_entry(6'd0, ra, ri);
      chk("R8 slot 0 overwritten", 32'(ra), 64);
      read_entry(6'd2, ra, ri);
      chk("R8 slot 2 older", 32'(ra), 2);
      repeat (5) @(negedge clk);
      chk("R8 wrapped sticky", 32'(wrapped), 1);

      // R9 rearm clears wrapped
      @(negedge clk) arm = 0;
      @(negedge clk) arm = 1;
      @(negedge clk);
      chk("R9 rearm clears wrapped", 32'(wrapped), 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule